// File: doc/BRIEF.md
# Flag Offset Byte Port

This block keeps the two threshold offsets that a FIFO's almost-empty and almost-full flag logic compares against. Each offset is 24 bits wide. Both offsets share one 8-bit port: software-style loading happens byte by byte on the write clock, and reading back happens byte by byte on the read clock through the same output register that normally carries FIFO data. A single load-select strobe chooses between normal FIFO traffic and offset traffic on both sides.

Both sides walk a fixed six-step order. The almost-empty offset comes first, low byte, then middle byte, then high byte. The almost-full offset follows in the same byte order. The write side and the read side each keep their own step pointer. A pointer wraps after the sixth step. It holds its place whenever the strobe is inactive, so a sequence that is cut short resumes where it left off. The two offsets are also driven out in parallel to the flag logic. They are treated as quasi-static, so no clock-domain crossing is done on them.

Top module: `ofs_regport`

## Requirements
- R1: While `rst` is high, on the following edge of each clock both step pointers return to step 0, both offsets take the value 127 (0x00007F), and `dout` becomes 0.
- R2: On a rising `clk_wr` edge with `ld_sel` and `wr_en` both high, `din` is stored into the byte selected by the write pointer, and the pointer advances by one step.
- R3: The step order is fixed as follows. Steps 0, 1 and 2 are bits [7:0], [15:8] and [23:16] of `ae_offset`. Steps 3, 4 and 5 are bits [7:0], [15:8] and [23:16] of `af_offset`.
- R4: The write pointer wraps from step 5 to step 0, so a seventh consecutive load overwrites the low byte of `ae_offset`.
- R5: A `clk_wr` edge with only one of `ld_sel` and `wr_en` high stores nothing and leaves the write pointer where it is.
- R6: On a rising `clk_rd` edge with `ld_sel` and `rd_en` high and `oe_n` low, `dout` takes the byte at the read pointer, and the read pointer advances. The byte is visible right after that edge.
- R7: The read pointer wraps from step 5 to step 0.
- R8: On a rising `clk_rd` edge with `rd_en` high and `ld_sel` low, `dout` takes `fifo_q` and the read pointer does not move.
- R9: A readback strobe while `oe_n` is high is ignored: `dout` and the read pointer both hold. A `clk_rd` edge with `rd_en` low also leaves `dout` unchanged.
- R10: The two pointers are independent. Loads never move the read pointer, and reads never move the write pointer, so a partial readback continues from its saved step after other traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_wr | input | 1 | Load-side clock |
| clk_rd | input | 1 | Readback-side clock |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| ld_sel | input | 1 | Selects offset traffic instead of FIFO traffic |
| wr_en | input | 1 | Write enable |
| rd_en | input | 1 | Read enable |
| oe_n | input | 1 | Active-low output enable; readback happens only when it is low |
| din | input | 8 | Load byte |
| fifo_q | input | 8 | Normal FIFO read data |
| dout | output | 8 | Registered output byte |
| ae_offset | output | 24 | Almost-empty offset, in parallel |
| af_offset | output | 24 | Almost-full offset, in parallel |

## Verification
The bench goes after the wrap of each pointer. A design that failed to wrap the write pointer would lose the seventh byte or write it to a nonexistent step. A read pointer that failed to wrap would read back garbage after the first full pass. Half-enabled write strobes and readback strobes with `oe_n` high must not advance a pointer; a design that advanced anyway would shift every later byte by one position. Plain FIFO reads are slipped into the middle of a readback, so a design that shared or cleared a pointer would return the wrong step when the sequence resumes.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  // Byte of a default offset that belongs to a given step.
  function automatic logic [63:0] default_byte(input int step, input int bpo,
                                               input int bw, input longint dflt);
    return 64'(dflt) >> (bw * (step % bpo));
  endfunction

  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,
    RD_FIFO = 2'd1,
    RD_OFS  = 2'd2
  } rd_kind_e;
endpackage

// File: rtl/ofs_step_ctr.sv
module ofs_step_ctr #(
  parameter int STEPS = 6,
  parameter int PW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [PW-1:0] ptr
);
  localparam logic [PW-1:0] LAST = PW'(STEPS - 1);

  always_ff @(posedge clk) begin
    if (rst)
      ptr <= '0;
    else if (adv)
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/ofs_bank.sv
module ofs_bank #(
  parameter int     BYTE_W  = 8,
  parameter int     BPO     = 3,
  parameter int     STEPS   = 6,
  parameter int     PW      = 3,
  parameter longint DEFAULT = 127
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [PW-1:0]           wptr,
  input  logic [BYTE_W-1:0]       din,
  output logic [STEPS*BYTE_W-1:0] flat
);
  for (genvar i = 0; i < STEPS; i++) begin : g_step
    localparam logic [BYTE_W-1:0] INIT =
      BYTE_W'(ofs_pkg::default_byte(i, BPO, BYTE_W, DEFAULT));
    logic [BYTE_W-1:0] byte_q;

    always_ff @(posedge clk) begin
      if (rst)
        byte_q <= INIT;
      else if (we && (wptr == PW'(i)))
        byte_q <= din;
    end

    assign flat[i*BYTE_W +: BYTE_W] = byte_q;
  end
endmodule

// File: rtl/ofs_readout.sv
module ofs_readout #(
  parameter int BYTE_W = 8,
  parameter int STEPS  = 6,
  parameter int PW     = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  ofs_pkg::rd_kind_e       kind,
  input  logic [PW-1:0]           rptr,
  input  logic [STEPS*BYTE_W-1:0] flat,
  input  logic [BYTE_W-1:0]       fifo_q,
  output logic [BYTE_W-1:0]       dout
);
  logic [BYTE_W-1:0] sel_byte;

  assign sel_byte = flat[rptr*BYTE_W +: BYTE_W];

  always_ff @(posedge clk) begin
    if (rst)
      dout <= '0;
    else begin
      case (kind)
        ofs_pkg::RD_FIFO: dout <= fifo_q;
        ofs_pkg::RD_OFS:  dout <= sel_byte;
        default:          dout <= dout;
      endcase
    end
  end
endmodule

// File: rtl/ofs_regport.sv
module ofs_regport #(
  parameter int     BYTE_W  = 8,
  parameter int     BPO     = 3,
  parameter longint DEFAULT = 127
) (
  input  logic                  clk_wr,
  input  logic                  clk_rd,
  input  logic                  rst,
  input  logic                  ld_sel,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic                  oe_n,
  input  logic [BYTE_W-1:0]     din,
  input  logic [BYTE_W-1:0]     fifo_q,
  output logic [BYTE_W-1:0]     dout,
  output logic [BYTE_W*BPO-1:0] ae_offset,
  output logic [BYTE_W*BPO-1:0] af_offset
);
  localparam int NOFF  = 2;
  localparam int STEPS = BPO * NOFF;
  localparam int PW    = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam int OFS_W = BYTE_W * BPO;

  logic [PW-1:0]           wr_ptr;
  logic [PW-1:0]           rd_ptr;
  logic                    wr_go;
  logic                    rd_go;
  logic [STEPS*BYTE_W-1:0] flat;
  ofs_pkg::rd_kind_e       kind;

  assign wr_go = ld_sel & wr_en;
  assign rd_go = ld_sel & rd_en & ~oe_n;

  always_comb begin
    if (rd_en && !ld_sel)
      kind = ofs_pkg::RD_FIFO;
    else if (rd_go)
      kind = ofs_pkg::RD_OFS;
    else
      kind = ofs_pkg::RD_IDLE;
  end

  ofs_step_ctr #(.STEPS(STEPS), .PW(PW)) u_wr_ctr (
    .clk (clk_wr),
    .rst (rst),
    .adv (wr_go),
    .ptr (wr_ptr)
  );

  ofs_step_ctr #(.STEPS(STEPS), .PW(PW)) u_rd_ctr (
    .clk (clk_rd),
    .rst (rst),
    .adv (rd_go),
    .ptr (rd_ptr)
  );

  ofs_bank #(
    .BYTE_W(BYTE_W), .BPO(BPO), .STEPS(STEPS), .PW(PW), .DEFAULT(DEFAULT)
  ) u_bank (
    .clk  (clk_wr),
    .rst  (rst),
    .we   (wr_go),
    .wptr (wr_ptr),
    .din  (din),
    .flat (flat)
  );

  ofs_readout #(.BYTE_W(BYTE_W), .STEPS(STEPS), .PW(PW)) u_out (
    .clk    (clk_rd),
    .rst    (rst),
    .kind   (kind),
    .rptr   (rd_ptr),
    .flat   (flat),
    .fifo_q (fifo_q),
    .dout   (dout)
  );

  assign ae_offset = flat[OFS_W-1:0];
  assign af_offset = flat[2*OFS_W-1:OFS_W];
endmodule

// File: rtl/ofs_regport_chk.sv
module ofs_regport_chk #(
  parameter int BYTE_W = 8,
  parameter int BPO    = 3,
  parameter int PW     = 3
) (
  input logic                  clk_wr,
  input logic                  clk_rd,
  input logic                  rst,
  input logic                  ld_sel,
  input logic                  wr_en,
  input logic                  rd_en,
  input logic                  oe_n,
  input logic [BYTE_W-1:0]     din,
  input logic [BYTE_W-1:0]     fifo_q,
  input logic [BYTE_W-1:0]     dout,
  input logic [BYTE_W*BPO-1:0] ae_offset,
  input logic [BYTE_W*BPO-1:0] af_offset,
  input logic [PW-1:0]         wr_ptr,
  input logic [PW-1:0]         rd_ptr
);
  localparam int STEPS = 2 * BPO;

  assert_wptr_range_R4: assert property (@(posedge clk_wr) disable iff (rst)
    int'(wr_ptr) < STEPS);

  assert_wptr_wrap_R4: assert property (@(posedge clk_wr) disable iff (rst)
    (ld_sel && wr_en && int'(wr_ptr) == STEPS - 1) |=> (wr_ptr == '0));

  assert_wptr_hold_R5: assert property (@(posedge clk_wr) disable iff (rst)
    !(ld_sel && wr_en) |=> $stable(wr_ptr));

  assert_ae_low_load_R2: assert property (@(posedge clk_wr) disable iff (rst)
    (ld_sel && wr_en && wr_ptr == '0) |=> (ae_offset[BYTE_W-1:0] == $past(din)));

  assert_rptr_wrap_R7: assert property (@(posedge clk_rd) disable iff (rst)
    (ld_sel && rd_en && !oe_n && int'(rd_ptr) == STEPS - 1) |=> (rd_ptr == '0));

  assert_fifo_path_R8: assert property (@(posedge clk_rd) disable iff (rst)
    (rd_en && !ld_sel) |=> (dout == $past(fifo_q)) && $stable(rd_ptr));

  assert_oe_block_R9: assert property (@(posedge clk_rd) disable iff (rst)
    (ld_sel && rd_en && oe_n) |=> $stable(dout) && $stable(rd_ptr));

  assert_af_low_read_R6: assert property (@(posedge clk_rd) disable iff (rst)
    (ld_sel && rd_en && !oe_n && int'(rd_ptr) == BPO)
      |=> (dout == $past(af_offset[BYTE_W-1:0])));
endmodule

bind ofs_regport ofs_regport_chk #(.BYTE_W(BYTE_W), .BPO(BPO), .PW(PW)) u_chk (
  .clk_wr    (clk_wr),
  .clk_rd    (clk_rd),
  .rst       (rst),
  .ld_sel    (ld_sel),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .oe_n      (oe_n),
  .din       (din),
  .fifo_q    (fifo_q),
  .dout      (dout),
  .ae_offset (ae_offset),
  .af_offset (af_offset),
  .wr_ptr    (wr_ptr),
  .rd_ptr    (rd_ptr)
);

// File: tb/sim_ofs_regport.sv
`timescale 1ns/1ps
module sim_ofs_regport;
  logic        clk_wr = 1'b0;
  logic        clk_rd = 1'b0;
  logic        rst    = 1'b1;
  logic        ld_sel = 1'b0;
  logic        wr_en  = 1'b0;
  logic        rd_en  = 1'b0;
  logic        oe_n   = 1'b0;
  logic [7:0]  din    = '0;
  logic [7:0]  fifo_q = '0;
  logic [7:0]  dout;
  logic [23:0] ae_offset;
  logic [23:0] af_offset;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk_wr = ~clk_wr;
  initial begin
    #3;
    forever #5 clk_rd = ~clk_rd;
  end

  ofs_regport u0 (
    .clk_wr    (clk_wr),
    .clk_rd    (clk_rd),
    .rst       (rst),
    .ld_sel    (ld_sel),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .oe_n      (oe_n),
    .din       (din),
    .fifo_q    (fifo_q),
    .dout      (dout),
    .ae_offset (ae_offset),
    .af_offset (af_offset)
  );

  task automatic check24(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%06h expected 0x%06h", tag, act, exp);
    end
  endtask

  // Monitor: each strobed read edge has one expected byte queued.
  initial begin
    forever begin
      @(posedge clk_rd);
      #2;
      if (exp_q.size() > 0) begin
        logic [7:0] e;
        string      t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (dout !== e) begin
          errors++;
          $display("FAIL %s: dout 0x%02h expected 0x%02h", t, dout, e);
        end
      end
    end
  end

  task automatic wr_cycle(input logic ld, input logic en, input logic [7:0] d);
    @(negedge clk_wr);
    ld_sel = ld; wr_en = en; din = d;
    @(posedge clk_wr);
    @(negedge clk_wr);
    ld_sel = 1'b0; wr_en = 1'b0;
  endtask

  task automatic rd_cycle(input logic ld, input logic en, input logic oe,
                          input logic [7:0] fq, input logic [7:0] e, input string tag);
    @(negedge clk_rd);
    ld_sel = ld; rd_en = en; oe_n = oe; fifo_q = fq;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk_rd);
    @(negedge clk_rd);
    ld_sel = 1'b0; rd_en = 1'b0; oe_n = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] ld_bytes[6];
    ld_bytes = '{8'hC3, 8'hA5, 8'h12, 8'h19, 8'h7F, 8'hE0};

    repeat (4) @(posedge clk_wr);
    @(negedge clk_wr);
    rst = 1'b0;
    #2;
    check24("R1 ae reset", ae_offset, 24'h00007F);
    check24("R1 af reset", af_offset, 24'h00007F);
    check24("R1 dout reset", {16'h0, dout}, 24'h0);

    // R1 R3: read back default bytes in step order
    rd_cycle(1, 1, 0, 8'h00, 8'h7F, "R1 R3 default ae low");
    rd_cycle(1, 1, 0, 8'h00, 8'h00, "R1 R3 default ae mid");
    rd_cycle(1, 1, 0, 8'h00, 8'h00, "R1 R3 default ae high");
    rd_cycle(1, 1, 0, 8'h00, 8'h7F, "R1 R3 default af low");
    rd_cycle(1, 1, 0, 8'h00, 8'h00, "R1 R3 default af mid");
    rd_cycle(1, 1, 0, 8'h00, 8'h00, "R1 R3 default af high");

    // R2 R3: full load sequence
    for (int i = 0; i < 6; i++) wr_cycle(1, 1, ld_bytes[i]);
    check24("R2 R3 ae loaded", ae_offset, 24'h12A5C3);
    check24("R2 R3 af loaded", af_offset, 24'hE07F19);

    // R6 R7: readback after read pointer wrapped once
    for (int i = 0; i < 6; i++) rd_cycle(1, 1, 0, 8'h00, ld_bytes[i], "R6 R7 readback");

    // R4: seventh load overwrites ae low byte
    wr_cycle(1, 1, 8'h55);
    check24("R4 wrap ae", ae_offset, 24'h12A555);
    check24("R4 wrap af", af_offset, 24'hE07F19);

    // R5: half-enabled writes do nothing
    wr_cycle(0, 1, 8'hAA);
    wr_cycle(1, 0, 8'hBB);
    check24("R5 ae unchanged", ae_offset, 24'h12A555);
    check24("R5 af unchanged", af_offset, 24'hE07F19);
    wr_cycle(1, 1, 8'h66);
    check24("R5 pointer held, ae mid", ae_offset, 24'h126655);

    // R8 R10: FIFO read does not move read pointer; write pointer is separate
    rd_cycle(0, 1, 0, 8'h3C, 8'h3C, "R8 fifo data");
    rd_cycle(1, 1, 0, 8'h00, 8'h55, "R10 read step0");
    // R9: strobe with output disabled, and strobe without rd_en
    rd_cycle(1, 1, 1, 8'h00, 8'h55, "R9 oe_n high hold");
    rd_cycle(1, 0, 0, 8'h00, 8'h55, "R9 rd_en low hold");
    rd_cycle(1, 1, 0, 8'h00, 8'h66, "R9 R10 read step1");
    rd_cycle(1, 1, 0, 8'h00, 8'h12, "R10 read step2");
    rd_cycle(0, 1, 0, 8'h81, 8'h81, "R8 fifo mid-sequence");
    rd_cycle(1, 1, 0, 8'h00, 8'h19, "R10 resume step3");
    rd_cycle(1, 1, 0, 8'h00, 8'h7F, "R10 read step4");
    rd_cycle(1, 1, 0, 8'h00, 8'hE0, "R10 read step5");
    rd_cycle(1, 1, 0, 8'h00, 8'h55, "R7 wrap to step0");

    repeat (3) @(posedge clk_rd);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule